// File: doc/BRIEF.md
# Teletext Bit Request Sequencer

This block sets the timing for placing one teletext packet on a video line. It runs on the 27 MHz pixel clock and watches an active-low horizontal sync input. A qualifying sync edge is a falling edge that arrives while insertion is enabled. Such an edge starts an offset counter. A fixed number of clocks later, the block opens a bit-pacing window of 360 teletext bits. The teletext bit rate is slightly above one bit per four clocks, so most bits last four clocks and a few fixed bits last three. The pattern repeats every 37 bits, which span exactly 144 clocks.

An upstream data source has some pipeline delay. To cover it, the block raises a request strobe that leads the sampling window by a programmable 0–15 clocks. The block samples the serial data input in the last clock of each bit slot. It presents the captured bit together with a one-cycle valid pulse. A downstream stage turns this bit stream into the filtered waveform on the line. The enable and the lead value are static inputs.

Top module: `ttx_req_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `ttx_req` and `bit_valid` are 0.
- R2: Number clock edges from the edge at which a falling edge of `hsync_n` is sampled with `ttx_en` high (edge 0). The first bit slot of the sampling window begins after clock edge 275.
- R3: Bits are numbered from 1 inside each group of 37. Bits 10, 19, 28 and 37 of each group last 3 clocks, and every other bit lasts 4 clocks. The group position is reset at the start of every window.
- R4: A window carries exactly 360 bits, which take 1402 clocks. After the last bit the window closes, and no further request or valid pulse occurs until the next qualifying edge.
- R5: With `lead_cycles` = D, `ttx_req` is high after clock edges 275−D through 1676−D and low at all other times during the line.
- R6: A bit slot that begins after edge s and lasts L clocks produces `bit_valid` = 1 for exactly one cycle, after edge s+L. In that cycle `bit_data` holds the value that `ttx_in` had in the slot's last clock, the one ending at edge s+L.
- R7: A falling edge of `hsync_n` while `ttx_en` is 0 opens no window. `ttx_req` and `bit_valid` stay 0.
- R8: A qualifying edge during a running line aborts that line. `ttx_req` and `bit_valid` are 0 after edge 0, and all timing, the bit count and the group position restart from the new edge.
- R9: A rising edge of `hsync_n`, or a held level, has no effect on a running line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Active-low horizontal sync |
| ttx_en | input | 1 | Static insertion enable |
| lead_cycles | input | 4 | Clocks by which the request leads the sampling window (0–15) |
| ttx_in | input | 1 | Serial teletext data from the source |
| ttx_req | output | 1 | Data request strobe to the source |
| bit_data | output | 1 | Last captured teletext bit |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_data` |

## Verification
The assertions assume that `ttx_en` and `lead_cycles` change only while no line is in progress. They also assume that `hsync_n` is synchronous to `clk`. The stimulus keeps to this: it changes enable and lead only just before it drives a sync edge, after the previous line has finished or on purpose to abort it. It drives every input on the falling clock edge. Each sync pulse stays low for 30 clocks, and its rising edge falls inside the offset period of a running line, which checks that rising edges are ignored.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

    // Line timing constants at a 27 MHz pixel clock
    localparam int OFFSET_CLKS  = 275;  // sync edge to first bit slot
    localparam int LINE_BITS    = 360;  // bits per inserted line
    localparam int GROUP_BITS   = 37;   // cadence repeat length in bits
    localparam int SHORT_STRIDE = 9;    // every 9th bit of a group is short
    localparam int LEAD_W       = 4;    // width of request lead field

    localparam int POS_W = $clog2(GROUP_BITS);
    localparam int CNT_W = $clog2(LINE_BITS);
    localparam int OFF_W = $clog2(OFFSET_CLKS + 1);

    typedef struct packed {
        logic             active;
        logic [1:0]       phase;  // clock within current bit slot
        logic [POS_W-1:0] pos;    // bit position inside the 37-bit group (0-based)
        logic [CNT_W-1:0] cnt;    // bits completed in this line
    } cad_state_t;

    // True for the three-clock bits: 1-based positions 10,19,28,37
    function automatic logic is_short(input logic [POS_W-1:0] pos);
        return (pos != '0) && ((int'(pos) % SHORT_STRIDE) == 0);
    endfunction

    // Index of the final clock of a slot at this position
    function automatic logic [1:0] last_phase(input logic [POS_W-1:0] pos);
        return is_short(pos) ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/ttx_sync_edge.sv
module ttx_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic hsync_n,
    input  logic ttx_en,
    output logic hs_fall,
    output logic qual_edge
);
    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst) hs_q <= 1'b1;
        else     hs_q <= hsync_n;
    end

    assign hs_fall   = hs_q & ~hsync_n;
    assign qual_edge = hs_fall & ttx_en;

endmodule

// File: rtl/ttx_offset_timer.sv
module ttx_offset_timer
    import ttx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [LEAD_W-1:0] lead,
    output logic              running,
    output logic              req_start,
    output logic              smp_start
);
    logic [OFF_W-1:0] off_cnt;
    logic [OFF_W-1:0] smp_at;
    logic [OFF_W-1:0] req_at;

    assign smp_at = OFF_W'(OFFSET_CLKS - 1);
    assign req_at = smp_at - {{(OFF_W-LEAD_W){1'b0}}, lead};

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            off_cnt <= '0;
        end else if (restart) begin
            running <= 1'b1;
            off_cnt <= '0;
        end else if (running) begin
            if (off_cnt == smp_at) running <= 1'b0;
            off_cnt <= off_cnt + 1'b1;
        end
    end

    assign req_start = running && (off_cnt == req_at);
    assign smp_start = running && (off_cnt == smp_at);

    AST_REQ_NOT_AFTER_SMP: assert property (@(posedge clk) disable iff (rst)
        smp_start |-> (lead == '0 ? req_start : !req_start)); // R5

endmodule

// File: rtl/ttx_cadence.sv
module ttx_cadence
    import ttx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic active,
    output logic slot_last
);
    cad_state_t st;
    logic       at_last;

    assign at_last = (st.phase == last_phase(st.pos));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (abort) begin
            st.active <= 1'b0;
        end else if (start) begin
            st.active <= 1'b1;
            st.phase  <= '0;
            st.pos    <= '0;
            st.cnt    <= '0;
        end else if (st.active) begin
            if (at_last) begin
                st.phase <= '0;
                st.pos   <= (st.pos == POS_W'(GROUP_BITS - 1)) ? '0 : st.pos + 1'b1;
                st.cnt   <= st.cnt + 1'b1;
                if (st.cnt == CNT_W'(LINE_BITS - 1)) st.active <= 1'b0;
            end else begin
                st.phase <= st.phase + 1'b1;
            end
        end
    end

    assign active    = st.active;
    assign slot_last = st.active & at_last;

    AST_SHORT_SLOT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st.active && is_short(st.pos) && st.phase == 2'd2 && !abort && !start) |=> (st.phase == 2'd0)); // R3

    AST_LONG_SLOT_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (st.active && !is_short(st.pos) && st.phase == 2'd2 && !abort && !start) |=> (st.phase == 2'd3)); // R3

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st.active |-> (st.cnt < CNT_W'(LINE_BITS))); // R4

    AST_FRESH_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (start && !abort) |=> (st.active && st.pos == '0 && st.cnt == '0)); // R8

endmodule

// File: rtl/ttx_req_seq.sv
module ttx_req_seq
    import ttx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_n,
    input  logic              ttx_en,
    input  logic [LEAD_W-1:0] lead_cycles,
    input  logic              ttx_in,
    output logic              ttx_req,
    output logic              bit_data,
    output logic              bit_valid
);
    localparam int NSEQ = 2;   // index 0: request side, 1: sampling side

    logic hs_fall, qual_edge;
    logic tmr_run, req_start, smp_start;
    logic [NSEQ-1:0] start_v, act_v, last_v;

    ttx_sync_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .hsync_n   (hsync_n),
        .ttx_en    (ttx_en),
        .hs_fall   (hs_fall),
        .qual_edge (qual_edge)
    );

    ttx_offset_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (qual_edge),
        .lead      (lead_cycles),
        .running   (tmr_run),
        .req_start (req_start),
        .smp_start (smp_start)
    );

    assign start_v = {smp_start, req_start};

    for (genvar g = 0; g < NSEQ; g++) begin : g_cad
        ttx_cadence u_cad (
            .clk       (clk),
            .rst       (rst),
            .start     (start_v[g]),
            .abort     (qual_edge),
            .active    (act_v[g]),
            .slot_last (last_v[g])
        );
    end

    assign ttx_req = act_v[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            bit_valid <= last_v[1] & ~qual_edge;
            if (last_v[1]) bit_data <= ttx_in;
        end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        qual_edge |=> (!ttx_req && !bit_valid)); // R8

    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (hs_fall && !ttx_en && !tmr_run) |=> !tmr_run); // R7

    AST_REQ_COVERS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(act_v[1]) |-> act_v[0]); // R5

    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(act_v[1])); // R6

    AST_REQ_CLOSES_AT_SLOT_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(act_v[0]) && !$past(qual_edge)) |-> $past(last_v[0])); // R4

endmodule

// File: tb/ttx_req_seq_test.sv
`timescale 1ns/1ps
module ttx_req_seq_test;

    localparam int OFF       = 275;
    localparam int LINE_CLKS = 1402;
    localparam int NBITS     = 360;
    localparam int FULL_SPAN = 1700;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_n = 1'b1;
    logic       ttx_en = 1'b0;
    logic [3:0] lead = 4'd0;
    logic       ttx_in = 1'b0;
    logic       ttx_req, bit_data, bit_valid;

    int  tick = 0;
    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    ttx_req_seq uut (
        .clk         (clk),
        .rst         (rst),
        .hsync_n     (hsync_n),
        .ttx_en      (ttx_en),
        .lead_cycles (lead),
        .ttx_in      (ttx_in),
        .ttx_req     (ttx_req),
        .bit_data    (bit_data),
        .bit_valid   (bit_valid)
    );

    always #2 clk = ~clk;

    always @(posedge clk) tick <= tick + 1;

    function automatic logic pat(input int x);
        return x[0] ^ x[2] ^ x[3] ^ x[5];
    endfunction

    always @(negedge clk) ttx_in <= pat(tick);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one sync edge and follow the line for span cycles
    task automatic run_line(input int d, input bit en, input int span, input string tag);
        int  t0, b, pos, nxt;
        bit  ereq, ev;
        lead   = 4'(d);
        ttx_en = en;
        @(negedge clk);
        hsync_n = 1'b0;
        t0  = tick + 1;
        b   = 0;
        pos = 0;
        nxt = OFF + 4;
        for (int n = 0; n <= span; n++) begin
            @(negedge clk);
            if (n == 30) hsync_n = 1'b1; // R9: rising edge inside a running line
            ereq = en && (n >= OFF - d) && (n <= OFF - d + LINE_CLKS - 1);
            chk(ttx_req == ereq, {tag, " R5 ttx_req"}, int'(ttx_req), int'(ereq));
            ev = en && (b < NBITS) && (n == nxt);
            chk(bit_valid == ev, {tag, " R2 R3 bit_valid"}, int'(bit_valid), int'(ev));
            if (ev) begin
                chk(bit_data == pat(t0 + n - 1), {tag, " R6 bit_data"},
                    int'(bit_data), int'(pat(t0 + n - 1)));
                b++;
                pos = (pos == 36) ? 0 : pos + 1;
                nxt += (pos != 0 && pos % 9 == 0) ? 3 : 4;
            end
        end
        if (en && span >= FULL_SPAN)
            chk(b == NBITS, {tag, " R4 bit count"}, b, NBITS);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(ttx_req == 1'b0, "R1 ttx_req in reset", int'(ttx_req), 0);
        chk(bit_valid == 1'b0, "R1 bit_valid in reset", int'(bit_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ttx_req == 1'b0, "R1 ttx_req after reset", int'(ttx_req), 0);
        chk(bit_valid == 1'b0, "R1 bit_valid after reset", int'(bit_valid), 0);

        // Sweep every lead value over a full line
        for (int d = 0; d < 16; d++) run_line(d, 1'b1, FULL_SPAN, "sweep");

        // R7: edge with enable low opens nothing
        run_line(7, 1'b0, FULL_SPAN, "R7 disabled");

        // R8: abort mid-window, then a full line from the new edge
        run_line(5, 1'b1, 600, "R8 pre-abort");
        run_line(5, 1'b1, FULL_SPAN, "R8 restart");

        // Abort during the offset period, before any request
        run_line(12, 1'b1, 100, "R8 early-abort");
        run_line(0, 1'b1, FULL_SPAN, "R8 after-early");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule